// File: doc/BRIEF.md
# Grouped Prescaler Tick Generator

This block derives five tick-enable strobes from a single free-running reference clock, for use by the count-down channels of a timer. Two 8-bit prescale counters divide the reference clock; the first feeds channels 0 and 1, the second feeds channels 2, 3 and 4. Each channel then applies its own power-of-two stage, selected by a 4-bit code, so its strobe rate is the reference rate divided by (prescale value + 1) × 2^code. Codes above 4 select divide-by-16.

Software programs two configuration words over a write-only register port: a prescale word and a divide-code word. A new setting never shortens a tick interval. A prescaler picks up its new value only when its counter wraps, and a channel picks up its new code only when its own power-of-two stage completes a period. The counters run whenever reset is released. Each strobe is high for exactly one clock per period, and it stays high on every cycle when the period is one clock.

Top module: `tmr_tick_gen`

## Requirements
- R1: After synchronous reset, the prescale word holds 1 in both groups and every divide code is 0. All ticks stay low while reset is asserted. Every channel strobes on the first sampled cycle after release and then every 2 cycles.
- R2: In steady state, channel c strobes every (P+1) × 2^E cycles. P is its group's prescale value and E is its effective divide code.
- R3: Channels 0 and 1 use prescale word bits [7:0]. Channels 2, 3 and 4 use prescale word bits [15:8].
- R4: Channel c takes its divide code from divide-code word bits [4c+3:4c].
- R5: A divide code of 5 to 15 behaves as code 4, which is divide-by-16.
- R6: With cfg_we high, cfg_sel=0 writes the prescale word and cfg_sel=1 writes the divide-code word. With cfg_we low, the data and select inputs have no effect.
- R7: Each tick is a single-cycle pulse. Over any window that is a multiple of its period, a channel strobes exactly window/period times.
- R8: After a configuration write, no interval between consecutive strobes of a channel is shorter than the smaller of its old and new periods. The new period is in force within one old period plus one new period.
- R9: A channel whose group prescale value and divide code are both unchanged by a write keeps exactly its period across that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 prescale word, 1 divide-code word |
| cfg_wdata | input | 20 | Write data for the selected word |
| tick_o | output | 5 | Per-channel single-cycle tick enables |

## Verification
The bench sweeps four prescale pairs. For each pair it steps the divide codes through all sixteen values, with the codes rotated across channels so that every code lands in every field position. This separates a wrong group mapping or a wrong field position from a wrong period formula. Every reconfiguration is measured across the write, so the bench can tell a correct deferred update from a shortened interval. A run-length window uses periods 1 to 16 to confirm single-cycle pulses and continuous strobing at period 1. Extreme cases cover a 255 prescale with divide-by-16, a write with the strobe low, and the reset sequence.

// File: rtl/tmr_tick_pkg.sv
// Shared definitions for the tick generator: configuration word selector
// encoding and reset defaults. Assumes one write port with a 1-bit select.
package tmr_tick_pkg;

    // Selects which configuration word a write updates
    typedef enum logic {
        CFG_PRESCALE = 1'b0,
        CFG_DIVCODE  = 1'b1
    } cfg_word_e;

    // Prescale value each group holds after reset
    localparam int RST_PRESCALE = 1;

endpackage

// File: rtl/tmr_cfg_regs.sv
// Holds the two configuration words as fields. Assumes the write strobe
// is synchronous to clk; only fields that downstream stages read are kept.
module tmr_cfg_regs
    import tmr_tick_pkg::*;
#(
    parameter int NUM_GRP = 2,
    parameter int NUM_CH  = 5,
    parameter int PRE_W   = 8,
    parameter int CODE_W  = 4,
    parameter int WORD_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic                      sel_i,
    input  logic [WORD_W-1:0]         wdata_i,
    output logic [NUM_GRP*PRE_W-1:0]  pre_flat_o,
    output logic [NUM_CH*CODE_W-1:0]  code_flat_o
);

    localparam int PRE_BITS  = NUM_GRP * PRE_W;
    localparam int CODE_BITS = NUM_CH * CODE_W;

    cfg_word_e sel_word;
    assign sel_word = cfg_word_e'(sel_i);

    // Capture a written word into its field register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_flat_o  <= {NUM_GRP{PRE_W'(RST_PRESCALE)}};
            code_flat_o <= '0;
        end else if (we_i) begin
            if (sel_word == CFG_PRESCALE) pre_flat_o  <= wdata_i[PRE_BITS-1:0];
            else                          code_flat_o <= wdata_i[CODE_BITS-1:0];
        end
    end

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(pre_flat_o) && $stable(code_flat_o)))
        else $error("configuration changed without a write");

    p_divsel_keeps_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i) |=> $stable(pre_flat_o))
        else $error("divide-code write altered prescale fields");

endmodule

// File: rtl/tmr_prescale_stage.sv
// One group prescaler: counts 0..P and pulses wrap_o on the last count.
// Assumes pre_i may change at any time; it is sampled only at the wrap.
module tmr_prescale_stage #(
    parameter int PRE_W   = 8,
    parameter int RST_PRE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_i,
    output logic             wrap_o
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] active_q;

    // Last count of the active prescale period reached
    assign wrap_o = (cnt_q == active_q);

    // Free-running count; new prescale value adopted only at a wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= PRE_W'(RST_PRE);
        end else if (wrap_o) begin
            cnt_q    <= '0;
            active_q <= pre_i;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    p_pre_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> $past(wrap_o))
        else $error("prescale value changed away from a wrap");

    p_wrap_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && (pre_i != '0)) |=> !wrap_o)
        else $error("wrap lasted more than one cycle");

endmodule

// File: rtl/tmr_pow2_stage.sv
// Per-channel power-of-two divider on prescaler wraps. Assumes wrap_i is
// a one-cycle enable; the divide code is sampled only at its own period end.
module tmr_pow2_stage #(
    parameter int CODE_W  = 4,
    parameter int MAX_EXP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);

    localparam int EXP_W  = $clog2(MAX_EXP + 1);
    localparam int SPAN_W = MAX_EXP + 1;

    logic [EXP_W-1:0]   exp_q;
    logic [MAX_EXP-1:0] cnt_q;
    logic [MAX_EXP-1:0] last_cnt;
    logic [EXP_W-1:0]   exp_next;
    logic [SPAN_W-1:0]  span;

    // Terminal count of the active power-of-two period
    always_comb begin
        span     = SPAN_W'(1) << exp_q;
        last_cnt = MAX_EXP'(span - 1'b1);
    end

    // Clamp oversized codes to the largest supported exponent
    assign exp_next = (code_i > CODE_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : EXP_W'(code_i);

    assign tick_o = wrap_i && (cnt_q == last_cnt);

    // Count wraps; adopt a new exponent only when a period completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
            exp_q <= exp_next;
        end else if (wrap_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_exp_at_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(exp_q) |-> $past(tick_o))
        else $error("exponent changed in mid period");

    p_exp_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (code_i > CODE_W'(MAX_EXP))) |=> (exp_q == EXP_W'(MAX_EXP)))
        else $error("oversized code not clamped");

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt)
        else $error("divider count beyond its period");

endmodule

// File: rtl/tmr_tick_gen.sv
// Top: two grouped prescalers and one power-of-two stage per channel.
// Channels below GRP0_CH use prescaler 0, the rest use prescaler 1.
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int PRE_W   = 8,
    parameter int CODE_W  = 4,
    parameter int MAX_EXP = 4,
    parameter int GRP0_CH = 2,
    localparam int NUM_GRP = 2,
    localparam int WORD_W  = (NUM_GRP * PRE_W > NUM_CH * CODE_W) ?
                             NUM_GRP * PRE_W : NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [NUM_CH-1:0] tick_o
);

    logic [NUM_GRP*PRE_W-1:0] pre_flat;
    logic [NUM_CH*CODE_W-1:0] code_flat;
    logic [NUM_GRP-1:0]       grp_wrap;

    tmr_cfg_regs #(
        .NUM_GRP (NUM_GRP),
        .NUM_CH  (NUM_CH),
        .PRE_W   (PRE_W),
        .CODE_W  (CODE_W),
        .WORD_W  (WORD_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we),
        .sel_i       (cfg_sel),
        .wdata_i     (cfg_wdata),
        .pre_flat_o  (pre_flat),
        .code_flat_o (code_flat)
    );

    // One prescaler per channel group
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
        tmr_prescale_stage #(
            .PRE_W   (PRE_W),
            .RST_PRE (RST_PRESCALE)
        ) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .pre_i  (pre_flat[g*PRE_W +: PRE_W]),
            .wrap_o (grp_wrap[g])
        );
    end

    // One power-of-two stage per channel, fed by its group's wrap
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = (c < GRP0_CH) ? 0 : 1;
        tmr_pow2_stage #(
            .CODE_W  (CODE_W),
            .MAX_EXP (MAX_EXP)
        ) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .wrap_i (grp_wrap[GRP]),
            .code_i (code_flat[c*CODE_W +: CODE_W]),
            .tick_o (tick_o[c])
        );

        p_tick_needs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[c] |-> grp_wrap[GRP])
            else $error("tick without its group's prescaler wrap");
    end

endmodule

// File: tb/tmr_tick_gen_bench.sv
module tmr_tick_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 5;
    localparam int WORD_W     = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [WORD_W-1:0] cfg_wdata = '0;
    logic [NCH-1:0]    tick_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    int m_pre [2];
    int m_code [NCH];
    int w_cnt [NCH];
    int w_min [NCH];
    int w_lastp [NCH];
    int w_first [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_tick_gen u_tmr_tick_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tick_o    (tick_o)
    );

    function automatic int period_of(input int ch);
        int e;
        e = (m_code[ch] > 4) ? 4 : m_code[ch];
        return (m_pre[(ch < 2) ? 0 : 1] + 1) << e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample ticks at negedges for ncyc cycles; drive a write at the first step
    task automatic window(input int ncyc, input logic we, input logic sel,
                          input logic [WORD_W-1:0] data);
        int last [NCH];
        for (int i = 0; i < NCH; i++) begin
            w_cnt[i] = 0; w_min[i] = 1 << 30; w_lastp[i] = 0; w_first[i] = -1; last[i] = 0;
        end
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) begin
                if (tick_o[i]) begin
                    if (w_cnt[i] > 0) begin
                        w_lastp[i] = t - last[i];
                        if (w_lastp[i] < w_min[i]) w_min[i] = w_lastp[i];
                    end else begin
                        w_first[i] = t;
                    end
                    last[i] = t;
                    w_cnt[i]++;
                end
            end
            if (t == 0) begin
                cfg_we = we; cfg_sel = sel; cfg_wdata = data;
            end else if (t == 1) begin
                cfg_we = 1'b0;
            end
        end
    endtask

    // Write a word, update the model, check periods across the change
    task automatic apply(input logic sel, input logic [WORD_W-1:0] data, input string tag);
        int oldp [NCH];
        int newp [NCH];
        int omax, nmax, lo;
        omax = 0; nmax = 0;
        for (int i = 0; i < NCH; i++) begin
            oldp[i] = period_of(i);
            if (oldp[i] > omax) omax = oldp[i];
        end
        if (sel == 1'b0) begin
            m_pre[0] = int'(data[7:0]);
            m_pre[1] = int'(data[15:8]);
        end else begin
            for (int i = 0; i < NCH; i++) m_code[i] = int'(data[4*i +: 4]);
        end
        for (int i = 0; i < NCH; i++) begin
            newp[i] = period_of(i);
            if (newp[i] > nmax) nmax = newp[i];
        end
        window(omax + 3 * nmax + 4, 1'b1, sel, data);
        for (int i = 0; i < NCH; i++) begin
            lo = (oldp[i] < newp[i]) ? oldp[i] : newp[i];
            if (sel && m_code[i] > 4)
                chk(w_lastp[i] == newp[i], $sformatf("R5 ch%0d code %0d", i, m_code[i]), w_lastp[i], newp[i]);
            else
                chk(w_lastp[i] == newp[i], $sformatf("%s ch%0d", tag, i), w_lastp[i], newp[i]);
            chk(w_min[i] >= lo, $sformatf("R8 ch%0d shortest interval", i), w_min[i], lo);
            if (oldp[i] == newp[i])
                chk(w_min[i] == newp[i], $sformatf("R9 ch%0d undisturbed", i), w_min[i], newp[i]);
        end
    endtask

    function automatic logic [WORD_W-1:0] codes_word(input int k);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < NCH; i++) w[4*i +: 4] = 4'((k + 3 * i) % 16);
        return w;
    endfunction

    initial begin
        int pairs [4];
        pairs[0] = 32'h0002; pairs[1] = 32'h0500; pairs[2] = 32'h0306; pairs[3] = 32'h0101;
        m_pre[0] = 1; m_pre[1] = 1;
        for (int i = 0; i < NCH; i++) m_code[i] = 0;

        // R1: reset behaviour
        repeat (4) @(negedge clk);
        chk(tick_o == '0, "R1 ticks low in reset", int'(tick_o), 0);
        rst_n = 1'b1;
        window(20, 1'b0, 1'b0, '0);
        for (int i = 0; i < NCH; i++) begin
            chk(w_first[i] == 0, $sformatf("R1 ch%0d first tick", i), w_first[i], 0);
            chk(w_lastp[i] == 2, $sformatf("R1 ch%0d period", i), w_lastp[i], 2);
            chk(w_cnt[i] == 10, $sformatf("R1 ch%0d count", i), w_cnt[i], 10);
        end

        // R2, R3, R4: sweep prescale pairs and rotated divide codes
        for (int j = 0; j < 4; j++) begin
            apply(1'b0, WORD_W'(pairs[j]), "R2/R3");
            for (int k = 0; k < 16; k++) apply(1'b1, codes_word(k), "R2/R4");
        end

        // R6: write strobe low leaves every period unchanged
        window(600, 1'b0, 1'b0, 20'hFFFFF);
        for (int i = 0; i < NCH; i++) begin
            chk(w_lastp[i] == period_of(i) && w_min[i] == period_of(i),
                $sformatf("R6 ch%0d ignored write", i), w_min[i], period_of(i));
        end
        window(600, 1'b0, 1'b1, 20'h00000);
        for (int i = 0; i < NCH; i++) begin
            chk(w_min[i] == period_of(i), $sformatf("R6 ch%0d ignored divsel", i), w_min[i], period_of(i));
        end

        // R9: change only channel 3's code
        apply(1'b1, (codes_word(15) & ~20'h0F000) | 20'h01000, "R4");

        // R7: periods 1,2,4,8,16 over a 64-cycle window
        apply(1'b0, 20'h00000, "R3");
        apply(1'b1, 20'h43210, "R4");
        window(64, 1'b0, 1'b0, '0);
        for (int i = 0; i < NCH; i++) begin
            chk(w_cnt[i] == (64 >> i), $sformatf("R7 ch%0d pulse count", i), w_cnt[i], 64 >> i);
        end

        // R5, R3: extreme prescale with oversized codes
        apply(1'b0, 20'h0FF00, "R3");
        apply(1'b1, 20'hFFF9F, "R4");
        apply(1'b0, 20'h00304, "R3");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
            $finish;
        end
    end

endmodule